// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block chooses where each of the two execute-stage ALU operands comes from in a five-stage in-order pipeline. An operand can be taken from the register file, or bypassed from one of two younger-than-the-file sources. The first is the ALU result waiting in the execute/memory register. The second is the value waiting in the memory/writeback register, which is either load data or an older ALU result. The choice is made from register numbers and write flags alone.

The selection logic is purely combinational. A thin test wrapper holds the three pipeline-register fields and the two operand multiplexers around it. Each clock edge the wrapper captures the following values from its inputs:

- the execute-stage source numbers and file values;
- the execute/memory destination, write flag and result;
- the memory/writeback destination, write flag and value.

During the following cycle the wrapper presents the selects and the chosen operand values. Register 31 reads as zero, so a destination of 31 is never bypassed.

Top module: `byp_unit_top`

## Requirements
- R1: Each operand select is 2 bits wide. The values are 2'b00 for the register file value, 2'b10 for the execute/memory result and 2'b01 for the memory/writeback value. The value 2'b11 never appears.
- R2: An operand selects 2'b10 when the execute/memory write flag is 1, its destination equals the operand's source number, and that destination is not 31.
- R3: If R2 does not apply, an operand selects 2'b01 when the memory/writeback write flag is 1, its destination equals the operand's source number, and that destination is not 31. Otherwise the select is 2'b00.
- R4: A stage whose destination is register 31 (all ones in the 5-bit field) never causes forwarding, even when the source number is also 31.
- R5: A stage whose write flag is 0 never causes forwarding, even when its destination matches.
- R6: When both stages qualify for the same source, the execute/memory result wins and the select is 2'b10.
- R7: Operands A and B follow identical rules, each judged only on its own source number.
- R8: Each operand output equals the register file value, the execute/memory result or the memory/writeback value, as named by its select. Selects and operands reflect the fields captured at the previous rising clock edge.
- R9: While reset is held, and after reset until new fields are loaded, all captured fields are zero. Both selects read 2'b00 and both operands read zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_src_a | input | 5 | Source register number of operand A |
| in_src_b | input | 5 | Source register number of operand B |
| in_rf_a | input | DW | Register file value of operand A |
| in_rf_b | input | DW | Register file value of operand B |
| in_mem_dst | input | 5 | Execute/memory destination register number |
| in_mem_we | input | 1 | Execute/memory register-write flag |
| in_mem_val | input | DW | Execute/memory ALU result |
| in_wb_dst | input | 5 | Memory/writeback destination register number |
| in_wb_we | input | 1 | Memory/writeback register-write flag |
| in_wb_val | input | DW | Memory/writeback value |
| sel_a | output | 2 | Source select of operand A |
| sel_b | output | 2 | Source select of operand B |
| opnd_a | output | DW | Selected value of operand A |
| opnd_b | output | DW | Selected value of operand B |

## Verification
The two bypass paths can qualify in the same cycle for the same operand. This happens when both later stages write the register being read, as in a chain of dependent adds. The bench provokes it by driving equal destinations on both stages with both write flags set. The select and value must then come from the execute/memory stage. The same sweep also covers these cases:

- a qualifying stage combined with a disabled write flag;
- a qualifying stage combined with destination 31;
- the two operands hitting different stages in one cycle.

A priority function written from the requirements judges every case.

// File: rtl/byp_pkg.sv
package byp_pkg;

  localparam int unsigned REG_NUM_W = 5;

  typedef enum logic [1:0] {
    SRC_REGFILE  = 2'b00,
    SRC_WBSTAGE  = 2'b01,
    SRC_MEMSTAGE = 2'b10
  } opnd_src_e;

endpackage

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
  import byp_pkg::*;
#(
  parameter int unsigned RW = REG_NUM_W
) (
  input  logic [RW-1:0] src_i,
  input  logic [RW-1:0] mem_dst_i,
  input  logic          mem_we_i,
  input  logic [RW-1:0] wb_dst_i,
  input  logic          wb_we_i,
  output opnd_src_e     sel_o
);

  localparam logic [RW-1:0] ZREG = {RW{1'b1}};

  logic mem_hit;
  logic wb_hit;

  always_comb begin
    mem_hit = mem_we_i && (mem_dst_i != ZREG) && (mem_dst_i == src_i);
    wb_hit  = wb_we_i  && (wb_dst_i  != ZREG) && (wb_dst_i  == src_i);
    if (mem_hit) begin
      sel_o = SRC_MEMSTAGE;
    end else if (wb_hit) begin
      sel_o = SRC_WBSTAGE;
    end else begin
      sel_o = SRC_REGFILE;
    end
  end

endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import byp_pkg::*;
#(
  parameter int unsigned RW   = REG_NUM_W,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0][RW-1:0] src_i,
  input  logic [RW-1:0]           mem_dst_i,
  input  logic                    mem_we_i,
  input  logic [RW-1:0]           wb_dst_i,
  input  logic                    wb_we_i,
  output opnd_src_e               sel_o [NSRC]
);

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    fwd_src_pick #(
      .RW(RW)
    ) i_pick (
      .src_i    (src_i[g]),
      .mem_dst_i(mem_dst_i),
      .mem_we_i (mem_we_i),
      .wb_dst_i (wb_dst_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (sel_o[g])
    );
  end

endmodule

// File: rtl/opnd_mux.sv
module opnd_mux
  import byp_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  opnd_src_e     sel_i,
  input  logic [DW-1:0] rf_i,
  input  logic [DW-1:0] mem_i,
  input  logic [DW-1:0] wb_i,
  output logic [DW-1:0] val_o
);

  always_comb begin
    case (sel_i)
      SRC_MEMSTAGE: val_o = mem_i;
      SRC_WBSTAGE:  val_o = wb_i;
      default:      val_o = rf_i;
    endcase
  end

endmodule

// File: rtl/byp_unit_top.sv
module byp_unit_top
  import byp_pkg::*;
#(
  parameter int unsigned RW = REG_NUM_W,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] in_src_a,
  input  logic [RW-1:0] in_src_b,
  input  logic [DW-1:0] in_rf_a,
  input  logic [DW-1:0] in_rf_b,
  input  logic [RW-1:0] in_mem_dst,
  input  logic          in_mem_we,
  input  logic [DW-1:0] in_mem_val,
  input  logic [RW-1:0] in_wb_dst,
  input  logic          in_wb_we,
  input  logic [DW-1:0] in_wb_val,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);

  localparam int unsigned NSRC = 2;
  localparam logic [RW-1:0] ZREG = {RW{1'b1}};

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  // pipeline-register fields: next state
  logic [NSRC-1:0][RW-1:0] ex_src_d, ex_src_q;
  logic [NSRC-1:0][DW-1:0] ex_rf_d, ex_rf_q;
  logic [RW-1:0]           mem_dst_d, mem_dst_q;
  logic                    mem_we_d, mem_we_q;
  logic [DW-1:0]           mem_val_d, mem_val_q;
  logic [RW-1:0]           wb_dst_d, wb_dst_q;
  logic                    wb_we_d, wb_we_q;
  logic [DW-1:0]           wb_val_d, wb_val_q;

  always_comb begin
    ex_src_d  = {in_src_b, in_src_a};
    ex_rf_d   = {in_rf_b, in_rf_a};
    mem_dst_d = in_mem_dst;
    mem_we_d  = in_mem_we;
    mem_val_d = in_mem_val;
    wb_dst_d  = in_wb_dst;
    wb_we_d   = in_wb_we;
    wb_val_d  = in_wb_val;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ex_src_q  <= '0;
      ex_rf_q   <= '0;
      mem_dst_q <= '0;
      mem_we_q  <= 1'b0;
      mem_val_q <= '0;
      wb_dst_q  <= '0;
      wb_we_q   <= 1'b0;
      wb_val_q  <= '0;
    end else begin
      ex_src_q  <= ex_src_d;
      ex_rf_q   <= ex_rf_d;
      mem_dst_q <= mem_dst_d;
      mem_we_q  <= mem_we_d;
      mem_val_q <= mem_val_d;
      wb_dst_q  <= wb_dst_d;
      wb_we_q   <= wb_we_d;
      wb_val_q  <= wb_val_d;
    end
  end

  // select logic
  opnd_src_e          sel [NSRC];
  logic [NSRC-1:0][DW-1:0] val;

  fwd_ctrl #(
    .RW  (RW),
    .NSRC(NSRC)
  ) i_fwd_ctrl (
    .src_i    (ex_src_q),
    .mem_dst_i(mem_dst_q),
    .mem_we_i (mem_we_q),
    .wb_dst_i (wb_dst_q),
    .wb_we_i  (wb_we_q),
    .sel_o    (sel)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_mux
    opnd_mux #(
      .DW(DW)
    ) i_mux (
      .sel_i(sel[g]),
      .rf_i (ex_rf_q[g]),
      .mem_i(mem_val_q),
      .wb_i (wb_val_q),
      .val_o(val[g])
    );

    // R1
    sel_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_q)
      $onehot0(sel[g]));

    // R4
    no_zero_reg_fwd_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (ex_src_q[g] == ZREG) |-> (sel[g] == SRC_REGFILE));

    // R5
    mem_we_low_chk: assert property (@(posedge clk) disable iff (!rst_q)
      !mem_we_q |-> (sel[g] != SRC_MEMSTAGE));

    // R5
    wb_we_low_chk: assert property (@(posedge clk) disable iff (!rst_q)
      !wb_we_q |-> (sel[g] != SRC_WBSTAGE));

    // R6
    newest_wins_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (mem_we_q && wb_we_q && (mem_dst_q == wb_dst_q) && (mem_dst_q == ex_src_q[g])
       && (mem_dst_q != ZREG)) |-> (sel[g] == SRC_MEMSTAGE));

    // R8
    opnd_value_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (sel[g] == SRC_WBSTAGE) |-> (val[g] == wb_val_q));
  end

  always_comb begin
    sel_a  = sel[0];
    sel_b  = sel[1];
    opnd_a = val[0];
    opnd_b = val[1];
  end

endmodule

// File: tb/test_byp_unit_top.sv
`timescale 1ns/100ps
module test_byp_unit_top;

  logic        clk;
  logic        rst_n;
  logic [4:0]  in_src_a, in_src_b, in_mem_dst, in_wb_dst;
  logic [31:0] in_rf_a, in_rf_b, in_mem_val, in_wb_val;
  logic        in_mem_we, in_wb_we;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int n_chk  = 0;
  int n_fail = 0;
  int n_vec  = 0;
  bit done   = 0;

  byp_unit_top i_byp_unit_top (
    .clk(clk), .rst_n(rst_n),
    .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_rf_a(in_rf_a), .in_rf_b(in_rf_b),
    .in_mem_dst(in_mem_dst), .in_mem_we(in_mem_we), .in_mem_val(in_mem_val),
    .in_wb_dst(in_wb_dst), .in_wb_we(in_wb_we), .in_wb_val(in_wb_val),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_sel(input logic [4:0] s, input logic [4:0] md,
                                         input logic mw, input logic [4:0] wd,
                                         input logic ww);
    if (mw && md != 5'd31 && md == s) return 2'b10;
    if (ww && wd != 5'd31 && wd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_of(input logic [4:0] s, input logic [4:0] md,
                                   input logic mw, input logic [4:0] wd,
                                   input logic ww);
    if (s == 5'd31 && (md == s || wd == s)) return "R4";
    if ((!mw && md == s) || (!ww && wd == s)) return "R5";
    if (mw && ww && md == s && wd == s) return "R6";
    if (mw && md == s) return "R2";
    return "R3";
  endfunction

  // drive one vector at the falling edge, capture at the rising edge, check after it
  task automatic apply(input logic [4:0] sa, input logic [4:0] sb,
                       input logic [4:0] md, input logic mw,
                       input logic [4:0] wd, input logic ww, input string note);
    logic [31:0] ra, rb, mv, wv;
    logic [1:0]  ea, eb;
    n_vec++;
    ra = 32'hA000_0000 | n_vec;
    rb = 32'hB000_0000 | n_vec;
    mv = 32'hE000_0000 | n_vec;
    wv = 32'hD000_0000 | n_vec;
    @(negedge clk);
    in_src_a = sa; in_src_b = sb; in_rf_a = ra; in_rf_b = rb;
    in_mem_dst = md; in_mem_we = mw; in_mem_val = mv;
    in_wb_dst = wd; in_wb_we = ww; in_wb_val = wv;
    @(posedge clk);
    #1;
    ea = ref_sel(sa, md, mw, wd, ww);
    eb = ref_sel(sb, md, mw, wd, ww);
    chk({note, tag_of(sa, md, mw, wd, ww)}, "sel_a", {30'd0, sel_a}, {30'd0, ea});
    chk({note, tag_of(sb, md, mw, wd, ww)}, "sel_b", {30'd0, sel_b}, {30'd0, eb});
    chk("R8", "opnd_a", opnd_a, (ea == 2'b10) ? mv : (ea == 2'b01) ? wv : ra);
    chk("R8", "opnd_b", opnd_b, (eb == 2'b10) ? mv : (eb == 2'b01) ? wv : rb);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    in_src_a = 5'd4; in_src_b = 5'd4; in_rf_a = 32'h1111_1111; in_rf_b = 32'h2222_2222;
    in_mem_dst = 5'd4; in_mem_we = 1'b1; in_mem_val = 32'h3333_3333;
    in_wb_dst = 5'd4; in_wb_we = 1'b1; in_wb_val = 32'h4444_4444;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "sel_a in reset", {30'd0, sel_a}, 32'd0);
    chk("R9", "sel_b in reset", {30'd0, sel_b}, 32'd0);
    chk("R9", "opnd_a in reset", opnd_a, 32'd0);
    chk("R9", "opnd_b in reset", opnd_b, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R9", "sel_a after release", {30'd0, sel_a}, 32'd0);
    chk("R9", "opnd_a after release", opnd_a, 32'd0);
    repeat (2) @(posedge clk);
  endtask

  task automatic t_sweep;
    logic [4:0] regs [3];
    regs[0] = 5'd3; regs[1] = 5'd7; regs[2] = 5'd31;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        for (int k = 0; k < 3; k++)
          for (int w = 0; w < 4; w++)
            apply(regs[i], regs[(i + 1) % 3], regs[j], w[1], regs[k], w[0], "sweep ");
  endtask

  task automatic t_chain;
    apply(5'd1, 5'd2, 5'd1, 1'b1, 5'd1, 1'b1, "chain ");
    apply(5'd1, 5'd1, 5'd1, 1'b1, 5'd1, 1'b1, "chain ");
  endtask

  task automatic t_indep;
    // R7: A takes the newer stage, B the older one, in one cycle
    apply(5'd9, 5'd12, 5'd9, 1'b1, 5'd12, 1'b1, "R7 ");
    apply(5'd12, 5'd9, 5'd9, 1'b1, 5'd12, 1'b1, "R7 ");
    apply(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, "R7 ");
  endtask

  task automatic t_latency;
    // R8: outputs follow the previously captured fields, then revert
    apply(5'd5, 5'd6, 5'd5, 1'b1, 5'd6, 1'b1, "R8 ");
    apply(5'd5, 5'd6, 5'd20, 1'b1, 5'd21, 1'b1, "R8 ");
  endtask

  initial begin
    t_reset;
    t_sweep;
    t_chain;
    t_indep;
    t_latency;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule